// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor core whose exception modes get private copies of some registers. The instruction stream names sixteen architectural registers, R0 to R15, but storage holds 31 physical words. The current processor mode picks which physical word each architectural number reaches. Fast-interrupt mode gets its own R8 to R12. Every exception mode gets its own stack pointer (R13) and link register (R14). User and System modes share one view. R0 to R7 and the program counter R15 are the same storage in every mode.

The core reads two operands and writes one result per cycle, all addressed by architectural number under the current mode. A second write port lets exception entry store the return address into the link register of the mode being entered, whatever the current mode is. Reads are combinational and see a write made in the same cycle. The block only stores R15; program-counter arithmetic and status registers belong elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: After reset every physical register reads as zero in every mode.
- R2: R0 to R7 are one set of storage shared by all modes.
- R3: In FIQ mode (code 10001), R8 to R12 map to a private copy. Every other mode shares the User copy.
- R4: Each of FIQ (10001), IRQ (10010), Supervisor (10011), Abort (10111) and Undef (11011) has its own R13 and R14. User (10000) and System (11111) share one R13/R14 pair.
- R5: R15 is one register shared by all modes.
- R6: With wr_en high, wr_data is stored at the clock edge into register wr_addr as seen in mode_i. With wr_en low, no register changes.
- R7: The two read ports are combinational and independent. A read of the register being written in the same cycle returns the value being written.
- R8: With exc_wr_en high, exc_lr_data is stored at the clock edge into R14 of the bank selected by exc_mode, independent of mode_i and of the main write.
- R9: When both write ports target the same physical register in one cycle, the exception value is stored, and reads of that register in that cycle return it.
- R10: A mode code not listed in R3/R4 selects the User view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode code |
| rd_a_addr | input | 4 | Read port A architectural register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B architectural register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Main write enable |
| wr_addr | input | 4 | Main write architectural register number |
| wr_data | input | 32 | Main write data |
| exc_wr_en | input | 1 | Exception link-register write enable |
| exc_mode | input | 5 | Mode whose R14 receives the exception write |
| exc_lr_data | input | 32 | Return address for the exception write |

## Verification
The main write port and the exception link-register port can land on the same physical word in one cycle. This happens when the current mode's R14 is also the R14 of the mode being entered. The bench provokes it by driving both enables at once with mode_i and exc_mode both set to Supervisor and wr_addr set to 14. It judges the result twice: the same-cycle read must return the exception value through the bypass, and the read after the edge must return the stored exception value. A second case points the two ports at different banks in the same cycle, and both writes must be kept.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  localparam int unsigned PHYS_REGS = 31;
  localparam int unsigned PIDX_W    = $clog2(PHYS_REGS);

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_code_e;

  typedef enum logic [2:0] {
    BANK_USR,
    BANK_FIQ,
    BANK_IRQ,
    BANK_SVC,
    BANK_ABT,
    BANK_UND
  } bank_e;

  // Physical layout: 0..15 user view, 16..20 fast R8..R12,
  // then SP/LR pairs for FIQ, IRQ, SVC, ABT, UND starting at 21.
  localparam int unsigned FIQ_HI_BASE = 16;
  localparam int unsigned SPLR_BASE   = 21;

endpackage

// File: rtl/regfile_reset_sync.sv
module regfile_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/regfile_bank_map.sv
module regfile_bank_map
  import banked_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [4:0]        mode,
  input  logic [ADDR_W-1:0] arch_idx,
  output logic [PIDX_W-1:0] phys_idx
);

  bank_e bank;
  int unsigned pair_base;

  always_comb begin
    unique case (mode)
      MODE_FIQ: bank = BANK_FIQ;
      MODE_IRQ: bank = BANK_IRQ;
      MODE_SVC: bank = BANK_SVC;
      MODE_ABT: bank = BANK_ABT;
      MODE_UND: bank = BANK_UND;
      default:  bank = BANK_USR;
    endcase
  end

  always_comb begin
    case (bank)
      BANK_FIQ: pair_base = SPLR_BASE;
      BANK_IRQ: pair_base = SPLR_BASE + 2;
      BANK_SVC: pair_base = SPLR_BASE + 4;
      BANK_ABT: pair_base = SPLR_BASE + 6;
      BANK_UND: pair_base = SPLR_BASE + 8;
      default:  pair_base = 13;
    endcase
  end

  always_comb begin
    phys_idx = PIDX_W'(arch_idx);
    if (arch_idx >= ADDR_W'(8) && arch_idx <= ADDR_W'(12)) begin
      if (bank == BANK_FIQ) begin
        phys_idx = PIDX_W'(FIQ_HI_BASE + 32'(arch_idx) - 8);
      end
    end else if (arch_idx == ADDR_W'(13) || arch_idx == ADDR_W'(14)) begin
      phys_idx = PIDX_W'(pair_base + 32'(arch_idx) - 13);
    end
  end

endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import banked_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_en,
  input  logic [PIDX_W-1:0] exc_idx,
  input  logic [DATA_W-1:0] exc_data,
  input  logic [PIDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [PIDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0]    mem_q [PHYS_REGS];
  logic [PHYS_REGS-1:0] we_main;
  logic [PHYS_REGS-1:0] we_exc;

  for (genvar i = 0; i < PHYS_REGS; i++) begin : g_entry
    logic [DATA_W-1:0] ent_d;
    logic              ent_ce;

    always_comb begin
      we_main[i] = wr_en  && (wr_idx  == PIDX_W'(i));
      we_exc[i]  = exc_en && (exc_idx == PIDX_W'(i));
      ent_ce     = we_main[i] || we_exc[i];
      ent_d      = we_exc[i] ? exc_data : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (ent_ce) begin
        mem_q[i] <= ent_d;
      end
    end
  end

  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];

  // Checker state: remembers the winning write to compare a cycle later.
  logic              chk_vld;
  logic [PIDX_W-1:0] chk_idx;
  logic [DATA_W-1:0] chk_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld  <= 1'b0;
      chk_idx  <= '0;
      chk_data <= '0;
    end else begin
      chk_vld  <= wr_en || exc_en;
      chk_idx  <= exc_en ? exc_idx : wr_idx;
      chk_data <= exc_en ? exc_data : wr_data;
    end
  end

  // R6, R8, R9: the selected write lands; exception wins on a shared target
  assert_write_commits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> mem_q[chk_idx] == chk_data);

  // R6: each write port targets at most one physical word
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_main) && $onehot0(we_exc));

  // R6: no enable means storage holds
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !exc_en |=> $stable(mem_q[0]) && $stable(mem_q[15]) && $stable(mem_q[30]));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              exc_wr_en,
  input  logic [4:0]        exc_mode,
  input  logic [DATA_W-1:0] exc_lr_data
);

  localparam logic [ADDR_W-1:0] LR_ARCH = ADDR_W'(14);

  logic              rst_sync_n;
  logic [PIDX_W-1:0] a_phys, b_phys, w_phys, x_phys;
  logic [DATA_W-1:0] a_store, b_store;

  regfile_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regfile_bank_map #(.ADDR_W(ADDR_W)) u_map_a (
    .mode (mode_i), .arch_idx (rd_a_addr), .phys_idx (a_phys));
  regfile_bank_map #(.ADDR_W(ADDR_W)) u_map_b (
    .mode (mode_i), .arch_idx (rd_b_addr), .phys_idx (b_phys));
  regfile_bank_map #(.ADDR_W(ADDR_W)) u_map_w (
    .mode (mode_i), .arch_idx (wr_addr), .phys_idx (w_phys));
  regfile_bank_map #(.ADDR_W(ADDR_W)) u_map_x (
    .mode (exc_mode), .arch_idx (LR_ARCH), .phys_idx (x_phys));

  regfile_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_idx    (w_phys),
    .wr_data   (wr_data),
    .exc_en    (exc_wr_en),
    .exc_idx   (x_phys),
    .exc_data  (exc_lr_data),
    .rd_a_idx  (a_phys),
    .rd_a_data (a_store),
    .rd_b_idx  (b_phys),
    .rd_b_data (b_store)
  );

  // Write-through bypass, exception port has priority (R7, R9)
  always_comb begin
    rd_a_data = a_store;
    if (exc_wr_en && x_phys == a_phys) begin
      rd_a_data = exc_lr_data;
    end else if (wr_en && w_phys == a_phys) begin
      rd_a_data = wr_data;
    end
  end

  always_comb begin
    rd_b_data = b_store;
    if (exc_wr_en && x_phys == b_phys) begin
      rd_b_data = exc_lr_data;
    end else if (wr_en && w_phys == b_phys) begin
      rd_b_data = wr_data;
    end
  end

  // R7: same-cycle write of the read register is visible
  assert_bypass_main_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && !exc_wr_en && rd_a_addr == wr_addr |-> rd_a_data == wr_data);

  // R9: exception value seen when both ports hit the read register
  assert_bypass_exc_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_wr_en && wr_en && exc_mode == mode_i && wr_addr == LR_ARCH && rd_b_addr == LR_ARCH
    |-> rd_b_data == exc_lr_data);

  // R2, R5: shared registers resolve identically on both ports in any mode
  assert_shared_views_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_a_addr == rd_b_addr) |-> rd_a_data == rd_b_data);

  // R1: storage is zero in the first cycle after reset release
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) && !wr_en && !exc_wr_en |-> a_store == '0 && b_store == '0);

endmodule

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i, exc_mode;
  logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data, exc_lr_data;
  logic        wr_en, exc_wr_en;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  banked_regfile dut_i (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
    .rd_a_addr (rd_a_addr), .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr), .rd_b_data (rd_b_data),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .exc_wr_en (exc_wr_en), .exc_mode (exc_mode), .exc_lr_data (exc_lr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    mode_i = m; wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [4:0] m, input logic [3:0] a,
                    input logic [31:0] exp);
    mode_i = m; rd_a_addr = a; rd_b_addr = a;
    #1;
    check(req, rd_a_data, exp);
    check(req, rd_b_data, exp);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 16; r++) begin
      rd("R1", USR, 4'(r), 32'h0);
      rd("R1", FIQ, 4'(r), 32'h0);
    end
    rd("R1", UND, 4'd14, 32'h0);
  endtask

  task automatic t_low_shared;
    wr(USR, 4'd3, 32'h0000_0303);
    wr(IRQ, 4'd7, 32'h0000_0707);
    rd("R2", FIQ, 4'd3, 32'h0000_0303);
    rd("R2", UND, 4'd7, 32'h0000_0707);
    rd("R2", SYS, 4'd3, 32'h0000_0303);
  endtask

  task automatic t_fiq_high;
    wr(USR, 4'd8,  32'hAAAA_0008);
    wr(FIQ, 4'd8,  32'hF1F1_0008);
    wr(SVC, 4'd12, 32'hAAAA_000C);
    rd("R3", FIQ, 4'd8,  32'hF1F1_0008);
    rd("R3", IRQ, 4'd8,  32'hAAAA_0008);
    rd("R3", FIQ, 4'd12, 32'h0);
    rd("R3", ABT, 4'd12, 32'hAAAA_000C);
  endtask

  task automatic t_sp_lr;
    wr(USR, 4'd13, 32'h5555_000D);
    wr(FIQ, 4'd13, 32'h1111_000D);
    wr(IRQ, 4'd13, 32'h2222_000D);
    wr(SVC, 4'd14, 32'h3333_000E);
    wr(ABT, 4'd14, 32'h4444_000E);
    wr(UND, 4'd13, 32'h6666_000D);
    rd("R4", SYS, 4'd13, 32'h5555_000D);
    rd("R4", FIQ, 4'd13, 32'h1111_000D);
    rd("R4", IRQ, 4'd13, 32'h2222_000D);
    rd("R4", SVC, 4'd14, 32'h3333_000E);
    rd("R4", ABT, 4'd14, 32'h4444_000E);
    rd("R4", UND, 4'd13, 32'h6666_000D);
    rd("R4", UND, 4'd14, 32'h0);
    rd("R4", USR, 4'd14, 32'h0);
  endtask

  task automatic t_pc;
    wr(FIQ, 4'd15, 32'h0000_8000);
    rd("R5", USR, 4'd15, 32'h0000_8000);
    rd("R5", UND, 4'd15, 32'h0000_8000);
  endtask

  task automatic t_wr_enable;
    @(negedge clk);
    mode_i = USR; wr_addr = 4'd3; wr_data = 32'hDEAD_BEEF; wr_en = 1'b0;
    @(negedge clk);
    rd("R6", USR, 4'd3, 32'h0000_0303);
    wr(USR, 4'd0, 32'h1234_5678);
    rd("R6", USR, 4'd0, 32'h1234_5678);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    mode_i = USR; wr_addr = 4'd5; wr_data = 32'hB0B0_0005; wr_en = 1'b1;
    rd_a_addr = 4'd5; rd_b_addr = 4'd3;
    #1;
    check("R7 bypass", rd_a_data, 32'hB0B0_0005);
    check("R7 other port", rd_b_data, 32'h0000_0303);
    @(negedge clk);
    wr_en = 1'b0;
    rd("R7 committed", USR, 4'd5, 32'hB0B0_0005);
  endtask

  task automatic t_exc;
    @(negedge clk);
    mode_i = USR; exc_mode = IRQ; exc_lr_data = 32'h0000_1004; exc_wr_en = 1'b1;
    wr_addr = 4'd14; wr_data = 32'h7777_000E; wr_en = 1'b1;
    @(negedge clk);
    exc_wr_en = 1'b0; wr_en = 1'b0;
    rd("R8 irq lr", IRQ, 4'd14, 32'h0000_1004);
    rd("R8 user lr", USR, 4'd14, 32'h7777_000E);
    rd("R8 svc lr", SVC, 4'd14, 32'h3333_000E);
  endtask

  task automatic t_collide;
    @(negedge clk);
    mode_i = SVC; exc_mode = SVC; exc_lr_data = 32'hE0E0_0008; exc_wr_en = 1'b1;
    wr_addr = 4'd14; wr_data = 32'h9999_9999; wr_en = 1'b1;
    rd_a_addr = 4'd14; rd_b_addr = 4'd14;
    #1;
    check("R9 same cycle", rd_a_data, 32'hE0E0_0008);
    check("R9 same cycle b", rd_b_data, 32'hE0E0_0008);
    @(negedge clk);
    exc_wr_en = 1'b0; wr_en = 1'b0;
    rd("R9 stored", SVC, 4'd14, 32'hE0E0_0008);
  endtask

  task automatic t_bad_mode;
    rd("R10 sp", BAD, 4'd13, 32'h5555_000D);
    rd("R10 r8", BAD, 4'd8, 32'hAAAA_0008);
    wr(BAD, 4'd14, 32'hBADD_000E);
    rd("R10 lr", USR, 4'd14, 32'hBADD_000E);
  endtask

  initial begin
    rst_n = 1'b0; mode_i = USR; exc_mode = USR;
    rd_a_addr = '0; rd_b_addr = '0; wr_addr = '0; wr_data = '0;
    exc_lr_data = '0; wr_en = 1'b0; exc_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_low_shared;
    t_fiq_high;
    t_sp_lr;
    t_pc;
    t_wr_enable;
    t_bypass;
    t_exc;
    t_collide;
    t_bad_mode;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule